// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor-side byte port and a line-wide main-memory port. A processor request carries a 24-bit byte address, a read/write command and one data byte. The address is split into a tag, a set index and a byte offset. The set index picks one set of two lines, and the stored tags of both lines are compared with the request tag. On a hit the selected byte is returned, or overwritten, in the cache alone. On a miss the controller loads the whole 4-byte line from memory into one line of the set and then serves the request from the cache. If the line it displaces holds data that was modified while cached, that line is first copied back to memory.

The number of sets is set by the parameter `SET_W` (the number of set-index bits). The nominal build uses `SET_W = 13`, which gives 8192 sets, 16384 lines and a 9-bit tag. The default of 4 keeps the storage small for simulation; the tag then widens to 18 bits. Processor requests are taken one at a time while `cpu_ready` is high. `cpu_done` pulses when a request completes.

Top module: `setassoc2_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `cpu_done` is 0, `mem_req` is 0, and every line is invalid, so the first access to any address misses.
- R2: Address bits [1:0] are the byte offset, bits [SET_W+1:2] are the set index, and bits [23:SET_W+2] are the tag. A memory transfer addresses a line by its byte address shifted right by 2, which is `{tag, set}`.
- R3: A request hits when either valid line of its set holds its tag. A hit makes no memory transfer, and `cpu_done` goes high one clock after the request is accepted. A set never holds the same tag in both lines.
- R4: A read miss fetches the whole line with exactly one memory read, then returns the addressed byte. `cpu_done` is a single-cycle pulse.
- R5: The offset selects byte `offset` of the 32-bit line, where byte k is bits [8k+7:8k]. A byte write leaves the other three bytes of the line unchanged.
- R6: A write hit changes the cached line only, with no memory transfer, and marks the line modified.
- R7: A write miss fetches the line, merges the written byte into it and leaves it modified. No memory write takes place at that time.
- R8: When both lines of a set are valid, a miss replaces the line that was used less recently.
- R9: An invalid line of the set is filled before any valid line is replaced. A freshly filled line is valid and unmodified.
- R10: A displaced line is written back to memory, as its full current 32-bit content at its own line address, only if it is modified. A clean line is dropped with no memory write.
- R11: Every hit and every fill makes the accessed line the more recently used one of its set.
- R12: The memory port carries one transfer at a time. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`. A write-back comes before the fill that replaces it, and `cpu_ready` is low while memory is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Request strobe, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid while `cpu_done` is high |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 22 | Line address `{tag, set}` |
| mem_wdata | output | 32 | Line being written back |
| mem_ack | input | 1 | Transfer complete; fetch data valid in this cycle |
| mem_rdata | input | 32 | Fetched line |

## Verification
A wrong valid bit or tag shows up on the memory port during the same request: there is either an extra line fetch or a missing one, and a hit takes three or more cycles longer than it should. A stale use-order bit stays hidden until the next miss in a full set. It then appears as the wrong line address on the port, and the line that should have survived misses on its next access. A lost modified bit is the slowest to surface: nothing shows until that line is displaced, when its write-back is missing, and a later read of it returns the old memory byte.

// File: rtl/sa2c_pkg.sv
package sa2c_pkg;
  localparam int ADDR_W     = 24;
  localparam int OFF_W      = 2;
  localparam int LINE_BYTES = 1 << OFF_W;
  localparam int LINE_W     = 8 * LINE_BYTES;
  localparam int LADDR_W    = ADDR_W - OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_REFILL
  } ctl_state_e;

  // byte k of a line sits in bits [8k+7:8k]
  function automatic logic [7:0] line_byte(input logic [LINE_W-1:0] line,
                                           input logic [OFF_W-1:0] off);
    return line[{off, 3'b000} +: 8];
  endfunction

  function automatic logic [LINE_W-1:0] line_merge(input logic [LINE_W-1:0] line,
                                                   input logic [OFF_W-1:0] off,
                                                   input logic [7:0] b);
    logic [LINE_W-1:0] r;
    r = line;
    r[{off, 3'b000} +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/sa2c_store.sv
module sa2c_store
  import sa2c_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int TAG_W = LADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  set_i,
  output logic [1:0]        way_valid,
  output logic [1:0]        way_dirty,
  output logic [TAG_W-1:0]  way_tag  [2],
  output logic [LINE_W-1:0] way_data [2],
  output logic              lru_way,
  input  logic              way_sel,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              touch_en
);
  localparam int SETS = 1 << SET_W;

  logic              valid_q [2][SETS];
  logic              dirty_q [2][SETS];
  logic [TAG_W-1:0]  tag_q   [2][SETS];
  logic [LINE_W-1:0] data_q  [2][SETS];
  logic              lru_q   [SETS];   // index of the less recently used way

  generate
    for (genvar w = 0; w < 2; w++) begin : g_way
      assign way_valid[w] = valid_q[w][set_i];
      assign way_dirty[w] = dirty_q[w][set_i];
      assign way_tag[w]   = tag_q[w][set_i];
      assign way_data[w]  = data_q[w][set_i];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SETS; s++) begin
            valid_q[w][s] <= 1'b0;
            dirty_q[w][s] <= 1'b0;
          end
        end else if (way_sel == w[0]) begin
          if (fill_en) begin
            valid_q[w][set_i] <= 1'b1;
            dirty_q[w][set_i] <= 1'b0;
          end else if (wr_en) begin
            dirty_q[w][set_i] <= 1'b1;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (way_sel == w[0]) begin
          if (fill_en) begin
            tag_q[w][set_i]  <= fill_tag;
            data_q[w][set_i] <= fill_data;
          end else if (wr_en) begin
            data_q[w][set_i] <= wr_data;
          end
        end
      end
    end
  endgenerate

  assign lru_way = lru_q[set_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= 1'b0;
    end else if (touch_en) begin
      lru_q[set_i] <= ~way_sel;
    end
  end

  AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> dirty_q[$past(way_sel)][$past(set_i)]); // R6
  AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(way_sel)][$past(set_i)] && !dirty_q[$past(way_sel)][$past(set_i)]); // R9
  AST_TOUCH_FLIPS_LRU: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> lru_q[$past(set_i)] != $past(way_sel)); // R11
endmodule

// File: rtl/sa2c_match.sv
module sa2c_match #(
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       way_valid,
  input  logic [TAG_W-1:0] way_tag [2],
  input  logic [TAG_W-1:0] want_tag,
  input  logic             lru_way,
  output logic [1:0]       hit_vec,
  output logic             hit,
  output logic             hit_way,
  output logic             victim_way
);
  generate
    for (genvar w = 0; w < 2; w++) begin : g_cmp
      assign hit_vec[w] = way_valid[w] && (way_tag[w] == want_tag);
    end
  endgenerate

  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];

  // an empty line is taken before the use order is consulted
  always_comb begin
    if (!way_valid[0])      victim_way = 1'b0;
    else if (!way_valid[1]) victim_way = 1'b1;
    else                    victim_way = lru_way;
  end

  AST_TAG_UNIQUE_IN_SET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R3
endmodule

// File: rtl/sa2c_ctrl.sv
module sa2c_ctrl
  import sa2c_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int TAG_W = LADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [7:0]        cpu_rdata,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              hit,
  input  logic              hit_way,
  input  logic              victim_way,
  input  logic [1:0]        way_valid,
  input  logic [1:0]        way_dirty,
  input  logic [TAG_W-1:0]  way_tag  [2],
  input  logic [LINE_W-1:0] way_data [2],
  output logic              way_sel,
  output logic              fill_en,
  output logic              wr_en,
  output logic [LINE_W-1:0] wr_data,
  output logic              touch_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ack
);
  ctl_state_e       state_q;
  logic             we_q;
  logic [7:0]       wdata_q;
  logic             vic_q;
  logic [SET_W-1:0] set_q;
  logic [OFF_W-1:0] off_q;
  logic             lookup_evt;
  logic             hit_evt;
  logic             miss_evt;

  assign set_q      = req_addr[OFF_W +: SET_W];
  assign off_q      = req_addr[OFF_W-1:0];
  assign lookup_evt = (state_q == ST_LOOKUP);
  assign hit_evt    = lookup_evt && hit;
  assign miss_evt   = lookup_evt && !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_addr  <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      vic_q     <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cpu_req) begin
          req_addr <= cpu_addr;
          we_q     <= cpu_we;
          wdata_q  <= cpu_wdata;
          state_q  <= ST_LOOKUP;
        end
        ST_LOOKUP: if (hit) begin
          if (!we_q) cpu_rdata <= line_byte(way_data[hit_way], off_q);
          cpu_done <= 1'b1;
          state_q  <= ST_IDLE;
        end else begin
          vic_q   <= victim_way;
          state_q <= (way_valid[victim_way] && way_dirty[victim_way]) ? ST_EVICT : ST_REFILL;
        end
        ST_EVICT:  if (mem_ack) state_q <= ST_REFILL;
        ST_REFILL: if (mem_ack) state_q <= ST_LOOKUP;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_EVICT) || (state_q == ST_REFILL);
  assign mem_we    = (state_q == ST_EVICT);
  assign mem_addr  = mem_we ? {way_tag[vic_q], set_q} : req_addr[ADDR_W-1:OFF_W];
  assign mem_wdata = way_data[vic_q];
  assign way_sel   = lookup_evt ? hit_way : vic_q;
  assign fill_en   = (state_q == ST_REFILL) && mem_ack;
  assign wr_en     = hit_evt && we_q;
  assign wr_data   = line_merge(way_data[hit_way], off_q, wdata_q);
  assign touch_en  = hit_evt || fill_en;

  AST_MEM_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12
  AST_MEM_BLOCKS_CPU: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready); // R12
  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> way_valid[vic_q] && way_dirty[vic_q]); // R10
  AST_HIT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst)
    hit_evt |=> !mem_req && cpu_done); // R3
  AST_MISS_GOES_TO_MEM: assert property (@(posedge clk) disable iff (rst)
    miss_evt |=> mem_req && !cpu_done); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done); // R4
endmodule

// File: rtl/setassoc2_cache.sv
module setassoc2_cache
  import sa2c_pkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cpu_req,
  input  logic         cpu_we,
  input  logic [23:0]  cpu_addr,
  input  logic [7:0]   cpu_wdata,
  output logic         cpu_ready,
  output logic         cpu_done,
  output logic [7:0]   cpu_rdata,
  output logic         mem_req,
  output logic         mem_we,
  output logic [21:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic         mem_ack,
  input  logic [31:0]  mem_rdata
);
  localparam int TAG_W = LADDR_W - SET_W;

  logic [ADDR_W-1:0] req_addr;
  logic [SET_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic [1:0]        way_valid, way_dirty, hit_vec;
  logic [TAG_W-1:0]  way_tag  [2];
  logic [LINE_W-1:0] way_data [2];
  logic              lru_way, hit, hit_way, victim_way;
  logic              way_sel, fill_en, wr_en, touch_en;
  logic [LINE_W-1:0] wr_data;

  assign req_set = req_addr[OFF_W +: SET_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  sa2c_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_store (
    .clk, .rst, .set_i(req_set),
    .way_valid, .way_dirty, .way_tag, .way_data, .lru_way,
    .way_sel, .fill_en, .fill_tag(req_tag), .fill_data(mem_rdata),
    .wr_en, .wr_data, .touch_en
  );

  sa2c_match #(.TAG_W(TAG_W)) u_match (
    .clk, .rst, .way_valid, .way_tag, .want_tag(req_tag), .lru_way,
    .hit_vec, .hit, .hit_way, .victim_way
  );

  sa2c_ctrl #(.SET_W(SET_W), .TAG_W(TAG_W)) u_ctrl (
    .clk, .rst, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_ready, .cpu_done, .cpu_rdata, .req_addr,
    .hit, .hit_way, .victim_way, .way_valid, .way_dirty, .way_tag, .way_data,
    .way_sel, .fill_en, .wr_en, .wr_data, .touch_en,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack
  );

  AST_FILL_MATCHES_REQ: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> mem_addr == req_addr[ADDR_W-1:OFF_W]); // R2
endmodule

// File: tb/sim_setassoc2_cache.sv
module sim_setassoc2_cache;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;
  localparam int TW = 22 - SW;
  localparam int MEM_LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready, cpu_done;
  logic [7:0]  cpu_rdata;
  logic        mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int compared = 0, mismatched = 0;
  int fill_cnt = 0, wb_cnt = 0, ev_seq = 0, fill_seq = 0, wb_seq = 0, wait_cnt = 0;
  logic [21:0] last_fill_addr, last_wb_addr;
  logic [31:0] last_wb_data;
  logic [31:0] mem_m [logic [21:0]];
  logic [31:0] ref_m [logic [21:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  setassoc2_cache #(.SET_W(SW)) u0 (
    .clk, .rst, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_ready, .cpu_done, .cpu_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata
  );

  function automatic logic [31:0] init_word(input logic [21:0] line);
    return {line, line[9:0]} ^ 32'h6B2D_91E7;
  endfunction
  function automatic logic [31:0] mem_word(input logic [21:0] line);
    return mem_m.exists(line) ? mem_m[line] : init_word(line);
  endfunction
  function automatic logic [31:0] ref_word(input logic [21:0] line);
    return ref_m.exists(line) ? ref_m[line] : init_word(line);
  endfunction
  function automatic logic [7:0] ref_byte(input logic [23:0] a);
    logic [31:0] w;
    w = ref_word(a[23:2]);
    return w[8*a[1:0] +: 8];
  endfunction
  function automatic logic [23:0] mk(input logic [TW-1:0] tag, input int set, input int off);
    return {tag, set[SW-1:0], off[1:0]};
  endfunction

  // memory model: acknowledges each transfer after MEM_LAT negedges
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wait_cnt = 0;
      end else if (mem_req) begin
        wait_cnt++;
        if (wait_cnt >= MEM_LAT) begin
          ev_seq++;
          if (mem_we) begin
            mem_m[mem_addr] = mem_wdata;
            wb_cnt++; wb_seq = ev_seq;
            last_wb_addr = mem_addr; last_wb_data = mem_wdata;
          end else begin
            mem_rdata = mem_word(mem_addr);
            fill_cnt++; fill_seq = ev_seq;
            last_fill_addr = mem_addr;
          end
          mem_ack = 1'b1;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [23:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int cyc, output int fills, output int wbs);
    int f0, w0;
    logic [31:0] w;
    f0 = fill_cnt; w0 = wb_cnt;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_done && cyc < 200);
    if (!cpu_done) check("R4 request never completed", 32'd0, 32'd1);
    rd = cpu_rdata; fills = fill_cnt - f0; wbs = wb_cnt - w0;
    if (we) begin
      w = ref_word(a[23:2]);
      w[8*a[1:0] +: 8] = d;
      ref_m[a[23:2]] = w;
    end
  endtask

  task automatic t_reset_and_first_miss();
    logic [7:0] rd; int c, f, w;
    check("R1 ready after reset", {31'd0, cpu_ready}, 32'd1);
    check("R1 done low after reset", {31'd0, cpu_done}, 32'd0);
    check("R1 no mem request after reset", {31'd0, mem_req}, 32'd0);
    cpu_op(1'b0, mk(18'h00001, 3, 2), 8'h00, rd, c, f, w);
    check("R1 first access misses (fills)", f, 1);
    check("R2 fill line address", {10'd0, last_fill_addr}, {10'd0, mk(18'h00001, 3, 2) >> 2});
    check("R4 read miss data", rd, ref_byte(mk(18'h00001, 3, 2)));
    check("R9 miss into empty set writes nothing", w, 0);
  endtask

  task automatic t_offsets_hit();
    logic [7:0] rd; int c, f, w;
    for (int o = 0; o < 4; o++) begin
      cpu_op(1'b0, mk(18'h00001, 3, o), 8'h00, rd, c, f, w);
      check($sformatf("R5 byte %0d of fetched line", o), rd, ref_byte(mk(18'h00001, 3, o)));
      check("R3 hit makes no fill", f, 0);
      check("R3 hit completes one cycle after accept", c, 1);
    end
  endtask

  task automatic t_second_way();
    logic [7:0] rd; int c, f, w;
    cpu_op(1'b0, mk(18'h00002, 3, 0), 8'h00, rd, c, f, w);
    check("R9 second tag fills empty way", f, 1);
    check("R9 no write-back", w, 0);
    cpu_op(1'b0, mk(18'h00001, 3, 1), 8'h00, rd, c, f, w);
    check("R9 first tag still resident", f, 0);
    check("R3 way hit data", rd, ref_byte(mk(18'h00001, 3, 1)));
    cpu_op(1'b0, mk(18'h00002, 3, 3), 8'h00, rd, c, f, w);
    check("R3 other way hits", f, 0);
    check("R3 other way data", rd, ref_byte(mk(18'h00002, 3, 3)));
  endtask

  task automatic t_lru_order();
    logic [7:0] rd; int c, f, w;
    cpu_op(1'b0, mk(18'h00001, 3, 0), 8'h00, rd, c, f, w);   // hit makes tag 1 recent
    check("R11 hit on tag 1", f, 0);
    cpu_op(1'b0, mk(18'h00003, 3, 2), 8'h00, rd, c, f, w);   // evicts tag 2
    check("R8 third tag misses", f, 1);
    check("R10 clean victim not written", w, 0);
    check("R4 data after replacement", rd, ref_byte(mk(18'h00003, 3, 2)));
    cpu_op(1'b0, mk(18'h00001, 3, 3), 8'h00, rd, c, f, w);
    check("R8 recently used line kept", f, 0);
    cpu_op(1'b0, mk(18'h00002, 3, 0), 8'h00, rd, c, f, w);
    check("R8 least recent line was replaced", f, 1);
    cpu_op(1'b0, mk(18'h00001, 3, 0), 8'h00, rd, c, f, w);
    check("R11 fill made tag 3 the victim, tag 1 kept", f, 0);
  endtask

  task automatic t_write_hit_and_dirty_evict();
    logic [7:0] rd; int c, f, w;
    cpu_op(1'b0, mk(18'h00004, 5, 0), 8'h00, rd, c, f, w);
    cpu_op(1'b1, mk(18'h00004, 5, 2), 8'hC3, rd, c, f, w);
    check("R6 write hit no fill", f, 0);
    check("R6 write hit no memory write", w, 0);
    check("R6 write hit one cycle", c, 1);
    cpu_op(1'b0, mk(18'h00004, 5, 2), 8'h00, rd, c, f, w);
    check("R5 written byte reads back", rd, 8'hC3);
    cpu_op(1'b0, mk(18'h00004, 5, 1), 8'h00, rd, c, f, w);
    check("R5 neighbour byte untouched", rd, ref_byte(mk(18'h00004, 5, 1)));
    cpu_op(1'b0, mk(18'h00006, 5, 0), 8'h00, rd, c, f, w);
    check("R9 empty way used before dirty line", w, 0);
    cpu_op(1'b0, mk(18'h00007, 5, 1), 8'h00, rd, c, f, w);
    check("R10 dirty victim written back", w, 1);
    check("R10 write-back line address", {10'd0, last_wb_addr}, {10'd0, mk(18'h00004, 5, 0) >> 2});
    check("R10 write-back line content", last_wb_data, ref_word(mk(18'h00004, 5, 0) >> 2));
    check("R12 write-back precedes fill", {31'd0, wb_seq < fill_seq}, 32'd1);
    check("R4 data after dirty replacement", rd, ref_byte(mk(18'h00007, 5, 1)));
    cpu_op(1'b0, mk(18'h00004, 5, 2), 8'h00, rd, c, f, w);
    check("R10 evicted write visible from memory", rd, 8'hC3);
    check("R10 evicted line refetched", f, 1);
  endtask

  task automatic t_write_miss();
    logic [7:0] rd; int c, f, w;
    cpu_op(1'b1, mk(18'h00008, 9, 1), 8'h77, rd, c, f, w);
    check("R7 write miss fetches line", f, 1);
    check("R7 write miss writes nothing", w, 0);
    cpu_op(1'b0, mk(18'h00008, 9, 1), 8'h00, rd, c, f, w);
    check("R7 merged byte hits", rd, 8'h77);
    check("R7 line resident", f, 0);
    cpu_op(1'b0, mk(18'h00008, 9, 0), 8'h00, rd, c, f, w);
    check("R7 rest of line from memory", rd, ref_byte(mk(18'h00008, 9, 0)));
    cpu_op(1'b0, mk(18'h0000A, 9, 0), 8'h00, rd, c, f, w);
    cpu_op(1'b0, mk(18'h0000B, 9, 0), 8'h00, rd, c, f, w);
    check("R7 write-miss line left dirty", w, 1);
    check("R7 written-back content", last_wb_data, ref_word(mk(18'h00008, 9, 0) >> 2));
    cpu_op(1'b0, mk(18'h0000C, 9, 0), 8'h00, rd, c, f, w);
    check("R10 clean line dropped silently", w, 0);
    check("R8 clean victim replaced", f, 1);
  endtask

  task automatic t_high_tag();
    logic [7:0] rd; int c, f, w;
    cpu_op(1'b0, mk(18'h3FFFF, 0, 3), 8'h00, rd, c, f, w);
    check("R2 top tag fill address", {10'd0, last_fill_addr}, {10'd0, mk(18'h3FFFF, 0, 3) >> 2});
    cpu_op(1'b0, mk(18'h1FFFF, 0, 3), 8'h00, rd, c, f, w);
    check("R2 tag differing in top bit misses", f, 1);
    check("R2 data for top-bit tag", rd, ref_byte(mk(18'h1FFFF, 0, 3)));
    cpu_op(1'b0, mk(18'h3FFFF, 0, 0), 8'h00, rd, c, f, w);
    check("R3 both top tags resident", f, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_and_first_miss();
    t_offsets_hit();
    t_second_way();
    t_lru_order();
    t_write_hit_and_dirty_evict();
    t_write_miss();
    t_high_tag();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule